// File: doc/BRIEF.md
# Hot Segment Chunk Wear Tracker

This block sits beside the address-translation logic of a phase-change storage controller and watches the stream of host writes. Each write names a chunk as a pair: segment number and chunk offset inside that segment. The block keeps write counters at chunk granularity only for a small window of segments. The window holds the segments written most recently and is ordered by recency. Segments outside the window cost no counter storage at all.

On a write whose segment is already in the window, the addressed chunk's counter advances and the segment becomes the most recently written. On a write to a segment outside the window, the least recently written entry is dropped. The new segment takes its place with every chunk counter cleared, and the write itself is then counted. When a write brings a counter up to the programmable threshold, the block stops accepting writes and asks a reserved-chunk pool for a fresh physical chunk. Once the pool grants one, the block clears that counter so counting resumes on the new chunk. It also reports the logical chunk and the granted physical chunk to the mapping logic in a one-cycle pulse.

The controller has two states. `ST_IDLE` accepts writes. The transition *threshold hit* is an accepted write whose new count equals the threshold, and it leads to `ST_ALLOC`. `ST_ALLOC` holds the allocation request and refuses writes. The transition *grant* is a sampled grant, and it leads back to `ST_IDLE` while launching the remap pulse.

Top module: `hot_chunk_tracker`

## Requirements
- R1: After reset, `wr_ready` is 1, `alloc_req` is 0, `remap_valid` is 0, and the window holds no segments, so the first write to any segment counts as a miss.
- R2: A write accepted (`wr_valid` and `wr_ready` high at a rising edge) to a segment in the window adds one to the counter of chunk `wr_off` of that segment; with threshold `THRESH`, the `THRESH`-th counted write to a chunk is the one that requests a new chunk.
- R3: Counters of different chunks are independent: writes to one offset of a segment never change how many further writes another offset of it needs to reach the threshold.
- R4: A segment entering the window starts with all chunk counters at 0, even if it was tracked and then evicted earlier; its inserting write counts as 1 on its chunk.
- R5: The window holds `DEPTH` distinct segments; a miss replaces the least recently written one, and every accepted write, hit or miss, makes its segment the most recently written.
- R6: In the cycle after the threshold-reaching write is accepted, `alloc_req` is 1 and `wr_ready` is 0; both stay so until a cycle in which `alloc_gnt` is sampled high.
- R7: In the cycle after `alloc_gnt` is sampled high with `alloc_req` high, `remap_valid` is 1 for exactly one cycle, with `remap_seg`/`remap_off` giving the logical chunk and `remap_phys` the `alloc_chunk` value sampled with the grant; `wr_ready` is 1 in that same cycle.
- R8: After the grant, the counter of the remapped chunk restarts at 0, so another `THRESH` writes to it request the next chunk.
- R9: While `alloc_req` is high, a presented write is not accepted and leaves the window and all counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request present |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_seg | input | SEG_W | Logical segment number of the write |
| wr_off | input | OFF_W | Chunk offset within the segment |
| alloc_req | output | 1 | Request for a reserved physical chunk |
| alloc_gnt | input | 1 | Pool grant; held low while the pool is empty |
| alloc_chunk | input | PHYS_W | Physical chunk number supplied with the grant |
| remap_valid | output | 1 | One-cycle remap event |
| remap_seg | output | SEG_W | Logical segment of the remapped chunk |
| remap_off | output | OFF_W | Chunk offset of the remapped chunk |
| remap_phys | output | PHYS_W | Newly allocated physical chunk |

## Verification
The bench builds the tracker with a window of 4 segments, 4 chunks per segment and a threshold of 5. Every eviction path, every counter crossing and every recency reordering therefore occurs within a few dozen writes. A pseudo-random sweep over six segments keeps the window constantly thrashing and repeatedly drives every chunk past the threshold. Delayed grants, with a refused write held at the port, exercise the stall path many times, and an ordered-list model in the bench predicts each allocation.

// File: rtl/hot_chunk_pkg.sv
package hot_chunk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ALLOC = 1'b1
    } trk_state_t;
endpackage

// File: rtl/htrk_tag_cam.sv
module htrk_tag_cam #(
    parameter int DEPTH = 32,
    parameter int SEG_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] look_seg,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [SEG_W-1:0] ins_seg
);
    logic [SEG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == look_seg);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end
    assign hit = |match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (ins_en) begin
            vld_q[ins_idx] <= 1'b1;
            tag_q[ins_idx] <= ins_seg;
        end
    end

    // R5: a segment occupies at most one window entry
    p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/htrk_recency.sv
module htrk_recency #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);
    logic [IDX_W-1:0] age_q [DEPTH];
    logic [DEPTH-1:0] is_oldest;

    for (genvar g = 0; g < DEPTH; g++) begin : g_old
        assign is_oldest[g] = (age_q[g] == IDX_W'(DEPTH - 1));
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (is_oldest[i]) oldest_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // R5: ages stay a permutation, so exactly one entry is the eviction choice
    p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_oldest) == 1);
    // R5: a touched entry becomes the youngest
    p_touch_youngest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (oldest_idx != $past(touch_idx)));
endmodule

// File: rtl/hot_chunk_tracker.sv
module hot_chunk_tracker
    import hot_chunk_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int CHUNKS  = 4,
    parameter int DEPTH   = 32,
    parameter int THRESH  = 100,
    parameter int PHYS_W  = 16,
    localparam int OFF_W  = $clog2(CHUNKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [OFF_W-1:0]  wr_off,
    output logic              alloc_req,
    input  logic              alloc_gnt,
    input  logic [PHYS_W-1:0] alloc_chunk,
    output logic              remap_valid,
    output logic [SEG_W-1:0]  remap_seg,
    output logic [OFF_W-1:0]  remap_off,
    output logic [PHYS_W-1:0] remap_phys
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(THRESH + 1);

    trk_state_t       state_q, state_d;
    logic             hit;
    logic [IDX_W-1:0] hit_idx, oldest_idx, tgt_idx;
    logic [CNT_W-1:0] cnt_q [DEPTH][CHUNKS];
    logic [CNT_W-1:0] cur_cnt, nxt_cnt;
    logic             accept, reach;
    logic [IDX_W-1:0] pend_idx;
    logic [SEG_W-1:0] pend_seg;
    logic [OFF_W-1:0] pend_off;

    htrk_tag_cam #(.DEPTH(DEPTH), .SEG_W(SEG_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .look_seg(wr_seg), .hit(hit), .hit_idx(hit_idx),
        .ins_en(accept && !hit), .ins_idx(oldest_idx), .ins_seg(wr_seg)
    );

    htrk_recency #(.DEPTH(DEPTH)) u_age (
        .clk(clk), .rst_n(rst_n),
        .touch_en(accept), .touch_idx(tgt_idx), .oldest_idx(oldest_idx)
    );

    assign accept  = wr_valid && wr_ready;
    assign tgt_idx = hit ? hit_idx : oldest_idx;
    assign cur_cnt = hit ? cnt_q[hit_idx][wr_off] : '0;
    assign nxt_cnt = cur_cnt + 1'b1;
    assign reach   = (nxt_cnt == CNT_W'(THRESH));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && reach) state_d = ST_ALLOC;
            ST_ALLOC: if (alloc_gnt)       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready  = 1'b0;
        alloc_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_ready  = 1'b1;
            ST_ALLOC: alloc_req = 1'b1;
            default:  wr_ready  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_valid <= 1'b0;
            remap_seg   <= '0;
            remap_off   <= '0;
            remap_phys  <= '0;
        end else begin
            remap_valid <= alloc_req && alloc_gnt;
            if (alloc_req && alloc_gnt) begin
                remap_seg  <= pend_seg;
                remap_off  <= pend_off;
                remap_phys <= alloc_chunk;
            end
        end
    end

    // pending chunk awaiting a reserved replacement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx <= '0;
            pend_seg <= '0;
            pend_off <= '0;
        end else if (accept && reach) begin
            pend_idx <= tgt_idx;
            pend_seg <= wr_seg;
            pend_off <= wr_off;
        end
    end

    // per-chunk counters of the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                for (int c = 0; c < CHUNKS; c++) cnt_q[i][c] <= '0;
        end else if (accept) begin
            if (!hit)
                for (int c = 0; c < CHUNKS; c++) cnt_q[tgt_idx][c] <= '0;
            cnt_q[tgt_idx][wr_off] <= nxt_cnt;
        end else if (alloc_req && alloc_gnt) begin
            cnt_q[pend_idx][pend_off] <= '0;
        end
    end

    // R2: a counted chunk never sits at or above the threshold when hit
    p_cnt_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |-> (cur_cnt < CNT_W'(THRESH)));
    // R6: request held until granted
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_gnt) |=> alloc_req);
    // R9: no write accepted while waiting for the pool
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> !wr_ready);
    // R7: grant produces a remap event next cycle
    p_remap_after_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_gnt) |=> remap_valid);
    // R7: remap event lasts one cycle
    p_remap_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remap_valid |=> !remap_valid);
    // R8: remapped chunk restarts from zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_gnt) |=> (cnt_q[$past(pend_idx)][$past(pend_off)] == '0));
endmodule

// File: tb/hot_chunk_tracker_tb_top.sv
module hot_chunk_tracker_tb_top;
    localparam int SEG_W  = 8;
    localparam int CHUNKS = 4;
    localparam int DEPTH  = 4;
    localparam int THRESH = 5;
    localparam int PHYS_W = 8;
    localparam int OFF_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [SEG_W-1:0] wr_seg = '0;
    logic [OFF_W-1:0] wr_off = '0;
    logic alloc_req;
    logic alloc_gnt = 1'b0;
    logic [PHYS_W-1:0] alloc_chunk = '0;
    logic remap_valid;
    logic [SEG_W-1:0] remap_seg;
    logic [OFF_W-1:0] remap_off;
    logic [PHYS_W-1:0] remap_phys;

    always #2 clk = ~clk;

    hot_chunk_tracker #(.SEG_W(SEG_W), .CHUNKS(CHUNKS), .DEPTH(DEPTH),
                        .THRESH(THRESH), .PHYS_W(PHYS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_seg(wr_seg), .wr_off(wr_off), .alloc_req(alloc_req),
        .alloc_gnt(alloc_gnt), .alloc_chunk(alloc_chunk),
        .remap_valid(remap_valid), .remap_seg(remap_seg),
        .remap_off(remap_off), .remap_phys(remap_phys)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int next_phys = 1;
    int alloc_cnt = 0;

    // recency-ordered model: position 0 is most recent
    int ms [DEPTH];
    bit mv [DEPTH];
    int mc [DEPTH][CHUNKS];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit model_write(input int s, input int o);
        int p = -1;
        int row [CHUNKS];
        bit res;
        for (int i = 0; i < DEPTH; i++) if (mv[i] && ms[i] == s) p = i;
        if (p >= 0) begin
            for (int c = 0; c < CHUNKS; c++) row[c] = mc[p][c];
        end else begin
            p = DEPTH - 1;
            for (int c = 0; c < CHUNKS; c++) row[c] = 0;
        end
        for (int i = p; i > 0; i--) begin
            ms[i] = ms[i-1]; mv[i] = mv[i-1];
            for (int c = 0; c < CHUNKS; c++) mc[i][c] = mc[i-1][c];
        end
        ms[0] = s; mv[0] = 1'b1;
        for (int c = 0; c < CHUNKS; c++) mc[0][c] = row[c];
        mc[0][o] = mc[0][o] + 1;
        res = (mc[0][o] == THRESH);
        if (res) mc[0][o] = 0;
        return res;
    endfunction

    task automatic grant(input int s, input int o, input bit stall, input string tag);
        if (stall) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_seg = SEG_W'(s + 1); wr_off = OFF_W'(o);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(wr_ready == 1'b0, "R9 stalled write refused", int'(wr_ready), 0);
                chk(alloc_req == 1'b1, "R6 request held", int'(alloc_req), 1);
            end
            wr_valid = 1'b0;
        end
        @(negedge clk);
        alloc_gnt = 1'b1; alloc_chunk = PHYS_W'(next_phys);
        @(negedge clk);
        alloc_gnt = 1'b0;
        chk(remap_valid == 1'b1, "R7 remap pulse", int'(remap_valid), 1);
        chk(int'(remap_seg) == s, {"R7 remap seg ", tag}, int'(remap_seg), s);
        chk(int'(remap_off) == o, "R7 remap off", int'(remap_off), o);
        chk(int'(remap_phys) == next_phys % 256, "R7 remap phys",
            int'(remap_phys), next_phys % 256);
        chk(wr_ready == 1'b1, "R7 ready with pulse", int'(wr_ready), 1);
        @(negedge clk);
        chk(remap_valid == 1'b0, "R7 pulse one cycle", int'(remap_valid), 0);
        next_phys++;
    endtask

    task automatic do_write(input int s, input int o, input string tag);
        bit ex;
        ex = model_write(s, o);
        chk(wr_ready == 1'b1, {"R6 ready before write ", tag}, int'(wr_ready), 1);
        wr_valid = 1'b1; wr_seg = SEG_W'(s); wr_off = OFF_W'(o);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(alloc_req == ex, {"alloc prediction ", tag}, int'(alloc_req), int'(ex));
        chk(wr_ready == !ex, {"R6 ready after write ", tag}, int'(wr_ready), int'(!ex));
        if (alloc_req) begin
            alloc_cnt++;
            grant(s, o, (alloc_cnt % 3) == 0, tag);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int lf;
        for (int i = 0; i < DEPTH; i++) begin
            mv[i] = 1'b0; ms[i] = 0;
            for (int c = 0; c < CHUNKS; c++) mc[i][c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b1, "R1 reset ready", int'(wr_ready), 1);
        chk(alloc_req == 1'b0, "R1 reset req", int'(alloc_req), 0);
        chk(remap_valid == 1'b0, "R1 reset remap", int'(remap_valid), 0);

        // R3: per-offset independence
        for (int o = 0; o < 3; o++)
            for (int k = 0; k < THRESH - 1; k++) do_write(10, o, "R3");
        do_write(10, 0, "R3 crossing");

        // R5: recency refresh and LRU eviction
        for (int k = 0; k < THRESH - 1; k++) do_write(10, 3, "R5");
        do_write(11, 0, "R5"); do_write(12, 0, "R5"); do_write(13, 0, "R5");
        do_write(10, 2, "R5 refresh");
        do_write(14, 0, "R5 evict oldest");
        do_write(10, 3, "R5 survivor");
        do_write(11, 0, "R5 reinserted");

        // R4: eviction then reinsertion restarts counters
        do_write(20, 0, "R4"); do_write(21, 0, "R4");
        do_write(22, 0, "R4"); do_write(23, 0, "R4");
        for (int k = 0; k < THRESH; k++) do_write(10, 2, "R4 fresh");

        // R8: repeated crossings on one chunk
        for (int k = 0; k < 3 * THRESH; k++) do_write(30, 1, "R8");

        // R2: sweep over six segments
        lf = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
            do_write(lf % 6, (lf >> 4) % 4, "R2 sweep");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule